// File: doc/BRIEF.md
# Flow-Control Update Priority Scheduler

This block sits on the receive side of a credit-based serial link layer. It decides when a flow-control update packet should go out, and at what urgency, so that the far-end transmitter learns how much receive-buffer space has been released here. It keeps three modular counters. The first counts the credits made available locally. The second counts the credits consumed by data that has arrived. The third holds the allocated value that was carried by the most recent update. A resend timer sits beside them.

An update request exists whenever the local allocation has moved past the advertised value, or whenever the resend timer has run out. The request normally has low priority. Three starvation rules can promote it:
- The far side holds less than one maximum payload of credit while fresh credit is waiting to be advertised.
- The resend timer has expired.
- At least a quarter of the receive buffer has been released without being advertised.

A small link arbiter chooses between the update, an acknowledge source and a transaction-packet source. It never interrupts a packet that is already on the link.

When the arbiter accepts an update, the current allocated count becomes the advertised value and the resend timer restarts. The promotion is then re-evaluated on the new values.

Top module: `fcu_sched`

## Requirements
- R1: After reset no grant is active, `upd_req` and `upd_hi` are 0, and `adv_credit` is 0. All credit counters start at 0.
- R2: The allocated count advances by `alloc_amt` on each cycle with `alloc_vld`, and the received count advances by `rcv_amt` on each cycle with `rcv_vld`. Both wrap modulo 2^CW. `upd_req` is 1 whenever the allocated count differs from `adv_credit` or the resend timer has expired.
- R3: `upd_hi` is 1 when both of these hold: `adv_credit` minus the received count is below MAX_PAYLOAD, and the allocated count is ahead of `adv_credit`. Neither half alone raises it.
- R4: The resend timer counts clock cycles from the last accepted update, or from reset. `upd_hi` and `upd_req` rise RESEND_CYCLES edges after that point and stay up until the next update is accepted.
- R5: `upd_hi` is 1 when the allocated count minus `adv_credit` is at least BUF_CREDITS/4. At BUF_CREDITS/4 - 1 it is 0 unless another rule holds.
- R6: When the link is free, the arbiter grants in this fixed order:
  1. the update at high priority;
  2. the acknowledge;
  3. the transaction packet;
  4. the update at low priority.

  The grant appears one cycle after the decision.
- R7: A grant is held unchanged until the granted source asserts its end-of-packet. A new decision is made in the cycle that end-of-packet is seen.
- R8: In the cycle the update wins, the allocated count is latched into `adv_credit`, which is visible with the grant. The timer restarts in the same cycle, and `upd_hi` is then recomputed from the new values.
- R9: Every credit difference is taken modulo 2^CW and read as signed at half the counter range. The rules therefore behave identically when the counters wrap past zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_vld | input | 1 | Local credits released this cycle |
| alloc_amt | input | AW | Number of credits released |
| rcv_vld | input | 1 | Received data consumed credit this cycle |
| rcv_amt | input | AW | Number of credits consumed |
| tlp_req | input | 1 | Transaction-packet source wants the link |
| tlp_eop | input | 1 | Last beat of the transaction packet |
| ack_req | input | 1 | Acknowledge source wants the link |
| ack_eop | input | 1 | Last beat of the acknowledge |
| upd_eop | input | 1 | Last beat of the update packet |
| gnt_tlp | output | 1 | Link granted to the transaction-packet source |
| gnt_ack | output | 1 | Link granted to the acknowledge source |
| gnt_upd | output | 1 | Link granted to the update |
| upd_req | output | 1 | An update is wanted |
| upd_hi | output | 1 | The update is promoted to high priority |
| adv_credit | output | CW | Allocated count carried by the latest update |

## Verification
Each promotion rule is driven to just below and just at its threshold while the other two rules are held false. The link is kept busy during these tests so that an accepted update cannot mask the result. A design that merged the two halves of the starvation rule, or that used the wrong comparison, would promote one step early or late.

The quarter-buffer rule is repeated with the advertised value just below the wrap point. An unsigned compare there would miss the promotion.

The timer is checked to the exact edge, both after an update and again after the next update. A timer that failed to restart, or that was off by one, would promote too early or too late.

Packets are held open while higher-priority requests appear, to expose any grant that moves in the middle of a packet. Random traffic is then compared cycle by cycle with a bench model of the rules.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
  localparam int NSRC    = 3;
  localparam int SRC_UPD = 0;
  localparam int SRC_ACK = 1;
  localparam int SRC_TLP = 2;

  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_UPD  = 2'd1,
    PICK_ACK  = 2'd2,
    PICK_TLP  = 2'd3
  } pick_e;
endpackage

// File: rtl/fcu_credit_track.sv
module fcu_credit_track #(
  parameter int CW          = 12,
  parameter int AW          = 8,
  parameter int MAX_PAYLOAD = 16,
  parameter int BUF_CREDITS = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_vld,
  input  logic [AW-1:0] alloc_amt,
  input  logic          rcv_vld,
  input  logic [AW-1:0] rcv_amt,
  input  logic          adv_take,
  output logic [CW-1:0] adv_val,
  output logic          pend,
  output logic          starve,
  output logic          backlog
);
  localparam logic signed [CW:0] MPS_L = (CW+1)'(MAX_PAYLOAD);
  localparam logic signed [CW:0] QTR_L = (CW+1)'(BUF_CREDITS / 4);

  logic [CW-1:0] alloc_q, alloc_d;
  logic [CW-1:0] rcv_q, rcv_d;
  logic [CW-1:0] adv_q, adv_d;
  logic [CW-1:0] unadv, remote;
  logic signed [CW:0] unadv_s, remote_s;

  // next-state
  always_comb begin
    alloc_d = alloc_q;
    rcv_d   = rcv_q;
    adv_d   = adv_q;
    if (alloc_vld) alloc_d = alloc_q + CW'(alloc_amt);
    if (rcv_vld)   rcv_d   = rcv_q + CW'(rcv_amt);
    if (adv_take)  adv_d   = alloc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alloc_q <= '0;
      rcv_q   <= '0;
      adv_q   <= '0;
    end else begin
      alloc_q <= alloc_d;
      rcv_q   <= rcv_d;
      adv_q   <= adv_d;
    end
  end

  // modular differences read as signed at half range
  assign unadv    = alloc_q - adv_q;
  assign remote   = adv_q - rcv_q;
  assign unadv_s  = $signed({unadv[CW-1], unadv});
  assign remote_s = $signed({remote[CW-1], remote});

  assign pend    = (unadv != '0);
  assign starve  = (remote_s < MPS_L) && !unadv_s[CW] && pend;
  assign backlog = (unadv_s >= QTR_L);
  assign adv_val = adv_q;

  // R8: advertised value takes the allocated count present at acceptance
  a_r8_adv_latch: assert property (@(posedge clk) disable iff (!rst_n)
    adv_take |=> adv_q == $past(alloc_q));
  // R5: backlog promotion only when something is unadvertised
  a_r5_backlog_pend: assert property (@(posedge clk) disable iff (!rst_n)
    backlog |-> pend);
  // R8: right after acceptance nothing new can be outstanding except this cycle's release
  a_r8_clear_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_take && !alloc_vld) |=> !pend);
endmodule

// File: rtl/fcu_resend_timer.sv
module fcu_resend_timer #(
  parameter int LIMIT = 3750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LIM_V = TW'(LIMIT);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          run_en;

  assign run_en = (cnt_q != LIM_V);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)     cnt_d = '0;
    else if (run_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == LIM_V);

  // R4: restart brings the count back to zero
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0);
  // R4: expiry persists until the next update is accepted
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !restart) |=> expired);
endmodule

// File: rtl/fcu_link_arb.sv
module fcu_link_arb
  import fcu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_hi,
  input  logic            upd_lo,
  input  logic            ack_req,
  input  logic            tlp_req,
  input  logic [NSRC-1:0] eop,
  output logic [NSRC-1:0] gnt,
  output logic            upd_win
);
  logic [NSRC-1:0] gnt_q, gnt_d;
  logic [NSRC-1:0] done_v;
  logic            busy, holder_done, choose;
  pick_e           pick;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_done
      assign done_v[g] = gnt_q[g] & eop[g];
    end
  endgenerate

  assign busy        = |gnt_q;
  assign holder_done = |done_v;
  assign choose      = !busy || holder_done;

  // fixed order: urgent update, acknowledge, transaction, routine update
  always_comb begin
    if (upd_hi)       pick = PICK_UPD;
    else if (ack_req) pick = PICK_ACK;
    else if (tlp_req) pick = PICK_TLP;
    else if (upd_lo)  pick = PICK_UPD;
    else              pick = PICK_NONE;
  end

  always_comb begin
    gnt_d = gnt_q;
    if (choose) begin
      gnt_d = '0;
      case (pick)
        PICK_UPD: gnt_d[SRC_UPD] = 1'b1;
        PICK_ACK: gnt_d[SRC_ACK] = 1'b1;
        PICK_TLP: gnt_d[SRC_TLP] = 1'b1;
        default:  gnt_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_q <= '0;
    else        gnt_q <= gnt_d;
  end

  assign upd_win = choose && (pick == PICK_UPD);
  assign gnt     = gnt_q;

  // R6: at most one source owns the link
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));
  // R7: no change in the middle of a packet
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !holder_done) |=> gnt_q == $past(gnt_q));
  // R6: an urgent update wins any free decision
  a_r6_hi_first: assert property (@(posedge clk) disable iff (!rst_n)
    (choose && upd_hi) |=> gnt_q[SRC_UPD]);
  // R6: acknowledge beats a transaction when no urgent update waits
  a_r6_ack_over_tlp: assert property (@(posedge clk) disable iff (!rst_n)
    (choose && !upd_hi && ack_req && tlp_req) |=> gnt_q[SRC_ACK]);
endmodule

// File: rtl/fcu_sched.sv
module fcu_sched
  import fcu_pkg::*;
#(
  parameter int CW            = 12,
  parameter int AW            = 8,
  parameter int MAX_PAYLOAD   = 16,
  parameter int BUF_CREDITS   = 1024,
  parameter int RESEND_CYCLES = 3750
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_vld,
  input  logic [AW-1:0] alloc_amt,
  input  logic          rcv_vld,
  input  logic [AW-1:0] rcv_amt,
  input  logic          tlp_req,
  input  logic          tlp_eop,
  input  logic          ack_req,
  input  logic          ack_eop,
  input  logic          upd_eop,
  output logic          gnt_tlp,
  output logic          gnt_ack,
  output logic          gnt_upd,
  output logic          upd_req,
  output logic          upd_hi,
  output logic [CW-1:0] adv_credit
);
  logic            pend, starve, backlog, expired, upd_win;
  logic [NSRC-1:0] eop_v, gnt_v;

  fcu_credit_track #(
    .CW(CW), .AW(AW), .MAX_PAYLOAD(MAX_PAYLOAD), .BUF_CREDITS(BUF_CREDITS)
  ) u_track (
    .clk(clk), .rst_n(rst_n),
    .alloc_vld(alloc_vld), .alloc_amt(alloc_amt),
    .rcv_vld(rcv_vld), .rcv_amt(rcv_amt),
    .adv_take(upd_win), .adv_val(adv_credit),
    .pend(pend), .starve(starve), .backlog(backlog)
  );

  fcu_resend_timer #(.LIMIT(RESEND_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(upd_win), .expired(expired)
  );

  assign upd_req = pend | expired;
  assign upd_hi  = starve | backlog | expired;

  assign eop_v[SRC_UPD] = upd_eop;
  assign eop_v[SRC_ACK] = ack_eop;
  assign eop_v[SRC_TLP] = tlp_eop;

  fcu_link_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .upd_hi(upd_hi), .upd_lo(upd_req & ~upd_hi),
    .ack_req(ack_req), .tlp_req(tlp_req),
    .eop(eop_v), .gnt(gnt_v), .upd_win(upd_win)
  );

  assign gnt_upd = gnt_v[SRC_UPD];
  assign gnt_ack = gnt_v[SRC_ACK];
  assign gnt_tlp = gnt_v[SRC_TLP];

  // R2: promotion never appears without a request
  a_r2_hi_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    upd_hi |-> upd_req);
  // R8: a fresh update grant carries the advertised value that was just latched
  a_r8_grant_value: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_upd) |-> !$stable(adv_credit) || !$past(pend) || $past(expired));
endmodule

// File: tb/test_fcu_sched.sv
module test_fcu_sched;
  localparam int CW  = 12;
  localparam int AW  = 8;
  localparam int MPS = 16;
  localparam int BUF = 1024;
  localparam int LIM = 3750;

  logic clk = 1'b0;
  logic rst_n;
  logic alloc_vld, rcv_vld, tlp_req, tlp_eop, ack_req, ack_eop, upd_eop;
  logic [AW-1:0] alloc_amt, rcv_amt;
  logic gnt_tlp, gnt_ack, gnt_upd, upd_req, upd_hi;
  logic [CW-1:0] adv_credit;

  always #4 clk = ~clk;

  fcu_sched #(.CW(CW), .AW(AW), .MAX_PAYLOAD(MPS), .BUF_CREDITS(BUF),
              .RESEND_CYCLES(LIM)) i_fcu_sched (
    .clk(clk), .rst_n(rst_n),
    .alloc_vld(alloc_vld), .alloc_amt(alloc_amt),
    .rcv_vld(rcv_vld), .rcv_amt(rcv_amt),
    .tlp_req(tlp_req), .tlp_eop(tlp_eop),
    .ack_req(ack_req), .ack_eop(ack_eop), .upd_eop(upd_eop),
    .gnt_tlp(gnt_tlp), .gnt_ack(gnt_ack), .gnt_upd(gnt_upd),
    .upd_req(upd_req), .upd_hi(upd_hi), .adv_credit(adv_credit)
  );

  int nchk  = 0;
  int nfail = 0;
  bit done_flag = 1'b0;

  // bench model state: bit0 update, bit1 ack, bit2 transaction
  logic [CW-1:0] m_alloc, m_rcv, m_adv;
  int            m_tmr;
  logic [2:0]    m_gnt;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic logic f_hi();
    logic [CW-1:0] un, rem;
    logic starv, back;
    un  = m_alloc - m_adv;
    rem = m_adv - m_rcv;
    starv = ($signed({rem[CW-1], rem}) < $signed(13'(MPS)))
            && !un[CW-1] && (un != '0);
    back  = $signed({un[CW-1], un}) >= $signed(13'(BUF/4));
    return starv || back || (m_tmr == LIM);
  endfunction

  function automatic logic f_req();
    return (m_alloc != m_adv) || (m_tmr == LIM);
  endfunction

  task automatic step(int ai, int ri, bit treq, bit teop, bit areq,
                      bit aeop, bit ueop);
    logic [2:0] ng;
    logic busy, fin, choose, win, hi, rq;
    logic [2:0] prev_gnt;
    alloc_vld = (ai > 0); alloc_amt = AW'(ai);
    rcv_vld   = (ri > 0); rcv_amt   = AW'(ri);
    tlp_req = treq; tlp_eop = teop; ack_req = areq; ack_eop = aeop;
    upd_eop = ueop;
    busy   = |m_gnt;
    fin    = |(m_gnt & {teop, aeop, ueop});
    choose = !busy || fin;
    hi = f_hi(); rq = f_req();
    if (hi)        ng = 3'b001;
    else if (areq) ng = 3'b010;
    else if (treq) ng = 3'b100;
    else if (rq)   ng = 3'b001;
    else           ng = 3'b000;
    win = choose && (ng == 3'b001);
    prev_gnt = m_gnt;
    if (win) begin m_adv = m_alloc; m_tmr = 0; end
    else if (m_tmr < LIM) m_tmr++;
    m_alloc = m_alloc + CW'(ai);
    m_rcv   = m_rcv + CW'(ri);
    if (choose) m_gnt = ng;
    @(posedge clk);
    @(negedge clk);
    chk("R6 grant", {29'd0, gnt_tlp, gnt_ack, gnt_upd}, {29'd0, m_gnt});
    if (busy && !fin)
      chk("R7 held grant", {29'd0, gnt_tlp, gnt_ack, gnt_upd}, {29'd0, prev_gnt});
    chk("R2 request", {31'd0, upd_req}, {31'd0, f_req()});
    chk("R3 priority", {31'd0, upd_hi}, {31'd0, f_hi()});
    chk("R8 advertised", {20'd0, adv_credit}, {20'd0, m_adv});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      nfail++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    rst_n = 1'b0;
    alloc_vld = 0; alloc_amt = '0; rcv_vld = 0; rcv_amt = '0;
    tlp_req = 0; tlp_eop = 0; ack_req = 0; ack_eop = 0; upd_eop = 0;
    m_alloc = '0; m_rcv = '0; m_adv = '0; m_tmr = 0; m_gnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 grants", {29'd0, gnt_tlp, gnt_ack, gnt_upd}, 32'd0);
    chk("R1 upd_req", {31'd0, upd_req}, 32'd0);
    chk("R1 upd_hi", {31'd0, upd_hi}, 32'd0);
    chk("R1 adv_credit", {20'd0, adv_credit}, 32'd0);

    // first update: starvation rule, link idle
    step(200, 0, 0, 0, 0, 0, 1);
    chk("R3 starving remote", {31'd0, upd_hi}, 32'd1);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R8 first grant", {31'd0, gnt_upd}, 32'd1);
    chk("R8 first value", {20'd0, adv_credit}, 32'd200);

    // quarter-buffer rule with link held by a transaction
    step(0, 0, 1, 0, 0, 0, 1);
    step(255, 0, 0, 0, 0, 0, 1);
    chk("R5 below quarter", {31'd0, upd_hi}, 32'd0);
    chk("R2 low request", {31'd0, upd_req}, 32'd1);
    step(1, 0, 0, 0, 0, 0, 1);
    chk("R5 at quarter", {31'd0, upd_hi}, 32'd1);
    chk("R7 no preempt", {31'd0, gnt_tlp}, 32'd1);
    step(0, 0, 0, 1, 1, 0, 1);
    chk("R6 urgent over ack", {31'd0, gnt_upd}, 32'd1);
    chk("R8 value 456", {20'd0, adv_credit}, 32'd456);
    chk("R8 promotion cleared", {31'd0, upd_hi}, 32'd0);

    // starvation rule: both halves needed, link held by ack
    step(0, 0, 0, 0, 1, 0, 1);
    step(0, 255, 0, 0, 0, 0, 1);
    step(0, 186, 0, 0, 0, 0, 1);
    chk("R3 low remote but nothing new", {31'd0, upd_hi}, 32'd0);
    step(1, 0, 0, 0, 0, 0, 1);
    chk("R3 both halves", {31'd0, upd_hi}, 32'd1);
    step(0, 0, 1, 0, 0, 1, 1);
    chk("R6 urgent over tlp", {31'd0, gnt_upd}, 32'd1);
    chk("R8 value 457", {20'd0, adv_credit}, 32'd457);

    // low priority ordering: remote holds exactly 16
    step(1, 0, 1, 0, 1, 0, 1);
    chk("R6 ack first", {31'd0, gnt_ack}, 32'd1);
    chk("R3 remaining 16 not urgent", {31'd0, upd_hi}, 32'd0);
    step(0, 0, 1, 0, 0, 1, 1);
    chk("R6 tlp over low update", {31'd0, gnt_tlp}, 32'd1);
    step(0, 0, 0, 1, 0, 0, 1);
    chk("R6 low update last", {31'd0, gnt_upd}, 32'd1);

    // resend timer: grant edge was in the step above
    step(0, 0, 1, 0, 0, 0, 1);
    for (int i = 2; i < LIM; i++) step(0, 0, 0, 0, 0, 0, 1);
    chk("R4 not yet expired", {31'd0, upd_hi}, 32'd0);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R4 expired urgent", {31'd0, upd_hi}, 32'd1);
    chk("R4 expired request", {31'd0, upd_req}, 32'd1);
    step(0, 0, 0, 1, 0, 0, 1);
    chk("R4 resend granted", {31'd0, gnt_upd}, 32'd1);
    for (int i = 1; i < LIM; i++) step(0, 0, 0, 0, 0, 0, 1);
    chk("R8 timer restarted", {31'd0, upd_hi}, 32'd0);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R8 restart full period", {31'd0, upd_hi}, 32'd1);
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);

    // wrap: bring advertised value to 4000
    for (int i = 0; i < 13; i++) step(255, 255, 0, 0, 0, 0, 1);
    step(227, 227, 0, 0, 0, 0, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 1);
    chk("R9 advertised near top", {20'd0, adv_credit}, 32'd4000);
    step(0, 0, 1, 0, 0, 0, 1);
    step(255, 0, 0, 0, 0, 0, 1);
    chk("R9 wrapped below quarter", {31'd0, upd_hi}, 32'd0);
    step(1, 0, 0, 0, 0, 0, 1);
    chk("R9 wrapped at quarter", {31'd0, upd_hi}, 32'd1);
    step(0, 0, 0, 1, 0, 0, 1);
    chk("R9 advertised after wrap", {20'd0, adv_credit}, 32'd160);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      int ai, ri;
      ai = ($urandom % 4 == 0) ? int'($urandom % 40) : 0;
      ri = ($urandom % 4 == 0) ? int'($urandom % 40) : 0;
      step(ai, ri, 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom));
    end

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule